// File: doc/BRIEF.md
# Processor Control and Status Register Unit

This unit keeps the control and status registers of a small 32-bit processor core. It holds a three-bit interrupt-enable register, the base addresses used for exception and debug entry, a debug control word, a free-running cycle counter, a fixed configuration word, and up to four breakpoint and four watchpoint address registers. The core's execute stage hands it the raw instruction word of a read-CSR or write-CSR instruction. For a write it also supplies the value of the source register. One cycle later the unit answers with a result that tells the register file whether, where and what to write back, and whether the instruction was illegal.

The core also signals the retirement of an exception return or a breakpoint return. On either event the unit restores the live interrupt-enable bit from the matching saved copy. The live enable bit, the two base addresses, the debug control word and the trigger address registers are driven on output ports for the interrupt, exception and debug logic around the core.

Top module: `csr_unit`

## Requirements
- R1: CSR number 0 is the interrupt-enable register, with live enable at bit 0, saved-on-exception copy at bit 1 and saved-on-breakpoint copy at bit 2. After reset it is 0. A write stores write-data bits 2:0, a read returns them zero-extended, and `int_en` shows bit 0.
- R2: When `exc_ret` is high, bit 0 of the interrupt-enable register takes the value bit 1 had before that clock edge, and bits 2:1 are unchanged. If `brk_ret` is high in the same cycle, `exc_ret` wins.
- R3: When `brk_ret` is high and `exc_ret` is low, bit 0 takes the value bit 2 had before that clock edge.
- R4: The CSR number is taken from instruction bits 25:21, the read destination from bits 15:11 and the write source from bits 20:16. Every read or write gives exactly one response one cycle later. A read's response has `rsp_wb` set, `rsp_dest` equal to its destination, and the register contents as they were at issue. A write is visible to a read issued in the next cycle.
- R5: CSR 1 (exception base), 2 (debug base) and 3 (debug control) are readable and writable, reset to 0, and are driven on `exc_base`, `dbg_base` and `dbg_ctl`.
- R6: CSR 4 is a cycle counter. It is 0 during reset, adds one on every clock edge after reset, wraps at 2^CYC_W, and ignores writes.
- R7: CSR 5 is a constant configuration word. Bits 3:0 hold NUM_BP, bits 7:4 hold NUM_WP and all other bits are 0. Writes to it are ignored.
- R8: A read of a write-only CSR returns 0. The write-only CSRs are 6 (instruction-cache control), 7 (data-cache control), 8 to 11 and 12 to 15. A read of an unassigned CSR (16 to 31) also returns 0. Writes to CSR 6, 7 or to an unassigned CSR change nothing and are legal.
- R9: A write to CSR 8+n loads breakpoint n and a write to CSR 12+n loads watchpoint n, for every n below NUM_BP or NUM_WP respectively. The value appears in bits n*32 +: 32 of `bp_addr` or `wp_addr`. Slots at or above the count always read 0 on those ports.
- R10: A write to breakpoint n with n >= NUM_BP, or to watchpoint n with n >= NUM_WP, sets `rsp_illegal` in its response and changes no register. Reads never set `rsp_illegal`.
- R11: `wr_src_idx` always equals instruction bits 20:16 in the same cycle, so the register file can supply `wr_data` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_rd | input | 1 | Read-CSR instruction issued this cycle |
| csr_wr | input | 1 | Write-CSR instruction issued this cycle |
| insn | input | 32 | Instruction word |
| wr_data | input | DATA_W | Value of the write source register |
| exc_ret | input | 1 | Exception return retired |
| brk_ret | input | 1 | Breakpoint return retired |
| wr_src_idx | output | 5 | Source register index of a write |
| rsp_valid | output | 1 | Response for the instruction issued last cycle |
| rsp_wb | output | 1 | Response carries read data to write back |
| rsp_dest | output | 5 | Destination register of a read |
| rsp_data | output | DATA_W | Read data (0 for writes) |
| rsp_illegal | output | 1 | Instruction was illegal |
| int_en | output | 1 | Live interrupt enable |
| exc_base | output | DATA_W | Exception base address |
| dbg_base | output | DATA_W | Debug exception base address |
| dbg_ctl | output | DATA_W | Debug control word |
| bp_addr | output | 4*DATA_W | Breakpoint registers, slot n at n*DATA_W |
| wp_addr | output | 4*DATA_W | Watchpoint registers, slot n at n*DATA_W |

## Verification
A read or write issued before a clock edge has its response on the `rsp_*` ports right after that edge. Register outputs and `int_en` also change on that same edge, after a write or return pulse. The driver sets inputs just after a falling edge and queues the expected response. The monitor compares the response at the next falling edge, which is exactly one register stage later. Direct-port checks are taken at that same falling edge. The expected value of a cycle-counter read comes from a counter in the bench that starts at reset release, taken when the read is issued.

// File: rtl/csr_unit_pkg.sv
package csr_unit_pkg;

    // CSR numbers whose position matters to software
    localparam logic [4:0] CSRN_IE       = 5'd0;
    localparam logic [4:0] CSRN_EXC_BASE = 5'd1;
    localparam logic [4:0] CSRN_DBG_BASE = 5'd2;
    localparam logic [4:0] CSRN_DBG_CTL  = 5'd3;
    localparam logic [4:0] CSRN_CYCLES   = 5'd4;
    localparam logic [4:0] CSRN_CONFIG   = 5'd5;
    localparam logic [4:0] CSRN_ICTL     = 5'd6;
    localparam logic [4:0] CSRN_DCTL     = 5'd7;
    localparam logic [2:0] CSRN_BP_GRP   = 3'b010;  // 8..11
    localparam logic [2:0] CSRN_WP_GRP   = 3'b011;  // 12..15

    // interrupt-enable register layout
    localparam int IE_W    = 3;
    localparam int IE_POS  = 0;
    localparam int EIE_POS = 1;
    localparam int BIE_POS = 2;

    localparam int MAX_TRIG   = 4;
    localparam int TRIG_IDX_W = $clog2(MAX_TRIG);

    typedef enum logic [3:0] {
        K_NONE,
        K_IE,
        K_EXC,
        K_DBGB,
        K_DBGC,
        K_CYC,
        K_CFG,
        K_WONLY,
        K_BP,
        K_WP
    } csr_kind_e;

    typedef struct packed {
        csr_kind_e               kind;
        logic [TRIG_IDX_W-1:0]   trig_idx;
        logic [4:0]              dest;
        logic [4:0]              src;
    } csr_dec_t;

endpackage

// File: rtl/csr_decode.sv
module csr_decode
    import csr_unit_pkg::*;
(
    input  logic [31:0] insn,
    output csr_dec_t    dec
);
    logic [4:0] num;
    logic       unused_insn_bits;

    assign num              = insn[25:21];
    assign unused_insn_bits = ^{insn[31:26], insn[10:0]};

    always_comb begin
        dec.dest     = insn[15:11];
        dec.src      = insn[20:16];
        dec.trig_idx = num[TRIG_IDX_W-1:0];
        case (num)
            CSRN_IE:       dec.kind = K_IE;
            CSRN_EXC_BASE: dec.kind = K_EXC;
            CSRN_DBG_BASE: dec.kind = K_DBGB;
            CSRN_DBG_CTL:  dec.kind = K_DBGC;
            CSRN_CYCLES:   dec.kind = K_CYC;
            CSRN_CONFIG:   dec.kind = K_CFG;
            CSRN_ICTL,
            CSRN_DCTL:     dec.kind = K_WONLY;
            default: begin
                if (num[4:2] == CSRN_BP_GRP)      dec.kind = K_BP;
                else if (num[4:2] == CSRN_WP_GRP) dec.kind = K_WP;
                else                              dec.kind = K_NONE;
            end
        endcase
    end
endmodule

// File: rtl/csr_ie_ctl.sv
module csr_ie_ctl
    import csr_unit_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IE_W-1:0] wr_bits,
    input  logic            exc_ret,
    input  logic            brk_ret,
    output logic [IE_W-1:0] ie_bits
);
    logic [IE_W-1:0] ie_d, ie_q;

    always_comb begin
        ie_d = ie_q;
        if (wr_en) ie_d = wr_bits;
        // return events restore the live bit from the copy held before this edge
        if (exc_ret)      ie_d[IE_POS] = ie_q[EIE_POS];
        else if (brk_ret) ie_d[IE_POS] = ie_q[BIE_POS];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ie_q <= '0;
        else        ie_q <= ie_d;
    end

    assign ie_bits = ie_q;

    p_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !exc_ret && !brk_ret) |=> (ie_bits == $past(wr_bits)));

    p_eret_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exc_ret |=> (ie_bits[IE_POS] == $past(ie_bits[EIE_POS])));

    p_saved_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((exc_ret || brk_ret) && !wr_en) |=> (ie_bits[2:1] == $past(ie_bits[2:1])));

    p_bret_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_ret && !exc_ret) |=> (ie_bits[IE_POS] == $past(ie_bits[BIE_POS])));
endmodule

// File: rtl/csr_trig_bank.sv
module csr_trig_bank
    import csr_unit_pkg::*;
#(
    parameter int NUM = 4,
    parameter int W   = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [TRIG_IDX_W-1:0] idx,
    input  logic [W-1:0]          wdata,
    output logic [MAX_TRIG*W-1:0] regs_o
);
    for (genvar g = 0; g < MAX_TRIG; g++) begin : g_slot
        if (g < NUM) begin : g_impl
            logic [W-1:0] slot_d, slot_q;
            always_comb begin
                slot_d = slot_q;
                if (we && idx == TRIG_IDX_W'(g)) slot_d = wdata;
            end
            always_ff @(posedge clk) begin
                if (!rst_n) slot_q <= '0;
                else        slot_q <= slot_d;
            end
            assign regs_o[g*W +: W] = slot_q;
        end else begin : g_absent
            assign regs_o[g*W +: W] = '0;
        end
    end

    // only implemented slots may ever be loaded
    p_slot_exists_r10: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(idx) < NUM));
endmodule

// File: rtl/csr_unit.sv
module csr_unit
    import csr_unit_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_BP = 4,
    parameter int NUM_WP = 4,
    parameter int CYC_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     csr_rd,
    input  logic                     csr_wr,
    input  logic [31:0]              insn,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     exc_ret,
    input  logic                     brk_ret,
    output logic [4:0]               wr_src_idx,
    output logic                     rsp_valid,
    output logic                     rsp_wb,
    output logic [4:0]               rsp_dest,
    output logic [DATA_W-1:0]        rsp_data,
    output logic                     rsp_illegal,
    output logic                     int_en,
    output logic [DATA_W-1:0]        exc_base,
    output logic [DATA_W-1:0]        dbg_base,
    output logic [DATA_W-1:0]        dbg_ctl,
    output logic [MAX_TRIG*DATA_W-1:0] bp_addr,
    output logic [MAX_TRIG*DATA_W-1:0] wp_addr
);
    localparam logic [DATA_W-1:0] CFG_WORD =
        DATA_W'(NUM_BP) | (DATA_W'(NUM_WP) << 4);

    typedef struct packed {
        logic [DATA_W-1:0] exc_base;
        logic [DATA_W-1:0] dbg_base;
        logic [DATA_W-1:0] dbg_ctl;
        logic [CYC_W-1:0]  cyc;
        logic              rsp_valid;
        logic              rsp_wb;
        logic [4:0]        rsp_dest;
        logic [DATA_W-1:0] rsp_data;
        logic              rsp_illegal;
    } state_t;

    state_t            st_d, st_q;
    csr_dec_t          dec;
    logic [IE_W-1:0]   ie_bits;
    logic [DATA_W-1:0] rd_val;
    logic              bp_ok, wp_ok, trig_fault;
    logic              ie_we, bp_we, wp_we;

    csr_decode u_dec (.insn(insn), .dec(dec));

    assign bp_ok      = int'(dec.trig_idx) < NUM_BP;
    assign wp_ok      = int'(dec.trig_idx) < NUM_WP;
    assign trig_fault = csr_wr && (((dec.kind == K_BP) && !bp_ok) ||
                                   ((dec.kind == K_WP) && !wp_ok));
    assign ie_we      = csr_wr && (dec.kind == K_IE);
    assign bp_we      = csr_wr && (dec.kind == K_BP) && bp_ok;
    assign wp_we      = csr_wr && (dec.kind == K_WP) && wp_ok;

    csr_ie_ctl u_ie (
        .clk(clk), .rst_n(rst_n), .wr_en(ie_we), .wr_bits(wr_data[IE_W-1:0]),
        .exc_ret(exc_ret), .brk_ret(brk_ret), .ie_bits(ie_bits)
    );

    csr_trig_bank #(.NUM(NUM_BP), .W(DATA_W)) u_bp (
        .clk(clk), .rst_n(rst_n), .we(bp_we), .idx(dec.trig_idx),
        .wdata(wr_data), .regs_o(bp_addr)
    );

    csr_trig_bank #(.NUM(NUM_WP), .W(DATA_W)) u_wp (
        .clk(clk), .rst_n(rst_n), .we(wp_we), .idx(dec.trig_idx),
        .wdata(wr_data), .regs_o(wp_addr)
    );

    always_comb begin
        case (dec.kind)
            K_IE:    rd_val = DATA_W'(ie_bits);
            K_EXC:   rd_val = st_q.exc_base;
            K_DBGB:  rd_val = st_q.dbg_base;
            K_DBGC:  rd_val = st_q.dbg_ctl;
            K_CYC:   rd_val = DATA_W'(st_q.cyc);
            K_CFG:   rd_val = CFG_WORD;
            default: rd_val = '0;   // write-only or unassigned
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.cyc = st_q.cyc + CYC_W'(1);
        if (csr_wr) begin
            case (dec.kind)
                K_EXC:   st_d.exc_base = wr_data;
                K_DBGB:  st_d.dbg_base = wr_data;
                K_DBGC:  st_d.dbg_ctl  = wr_data;
                default: ;
            endcase
        end
        st_d.rsp_valid   = csr_rd || csr_wr;
        st_d.rsp_wb      = csr_rd;
        st_d.rsp_dest    = csr_rd ? dec.dest : 5'd0;
        st_d.rsp_data    = csr_rd ? rd_val : '0;
        st_d.rsp_illegal = trig_fault;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_src_idx  = dec.src;
    assign rsp_valid   = st_q.rsp_valid;
    assign rsp_wb      = st_q.rsp_wb;
    assign rsp_dest    = st_q.rsp_dest;
    assign rsp_data    = st_q.rsp_data;
    assign rsp_illegal = st_q.rsp_illegal;
    assign int_en      = ie_bits[IE_POS];
    assign exc_base    = st_q.exc_base;
    assign dbg_base    = st_q.dbg_base;
    assign dbg_ctl     = st_q.dbg_ctl;

    p_one_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({csr_rd, csr_wr}));

    p_rsp_due_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rd || csr_wr) |=> rsp_valid);

    p_rsp_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_rd || csr_wr) |=> !rsp_valid);

    p_base_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_wr && dec.kind == K_EXC) |=> $stable(exc_base));

    p_cycle_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.cyc == $past(st_q.cyc) + CYC_W'(1)));

    p_cfg_const_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rd && dec.kind == K_CFG) |=> (rsp_data == CFG_WORD));

    p_wonly_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rd && (dec.kind == K_WONLY || dec.kind == K_BP ||
                    dec.kind == K_WP || dec.kind == K_NONE)) |=> (rsp_data == '0));

    p_ill_from_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_illegal |-> $past(csr_wr));

    p_read_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rd |=> !rsp_illegal);
endmodule

// File: tb/tb_csr_unit.sv
module tb_csr_unit;
    localparam int DW = 32;
    localparam int NBP = 2;
    localparam int NWP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csr_rd = 1'b0, csr_wr = 1'b0, exc_ret = 1'b0, brk_ret = 1'b0;
    logic [31:0] insn = '0;
    logic [DW-1:0] wr_data = '0;
    logic [4:0] wr_src_idx, rsp_dest;
    logic rsp_valid, rsp_wb, rsp_illegal, int_en;
    logic [DW-1:0] rsp_data, exc_base, dbg_base, dbg_ctl;
    logic [4*DW-1:0] bp_addr, wp_addr;

    csr_unit #(.DATA_W(DW), .NUM_BP(NBP), .NUM_WP(NWP), .CYC_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .csr_rd(csr_rd), .csr_wr(csr_wr), .insn(insn),
        .wr_data(wr_data), .exc_ret(exc_ret), .brk_ret(brk_ret),
        .wr_src_idx(wr_src_idx), .rsp_valid(rsp_valid), .rsp_wb(rsp_wb),
        .rsp_dest(rsp_dest), .rsp_data(rsp_data), .rsp_illegal(rsp_illegal),
        .int_en(int_en), .exc_base(exc_base), .dbg_base(dbg_base),
        .dbg_ctl(dbg_ctl), .bp_addr(bp_addr), .wp_addr(wp_addr)
    );

    always #2 clk = ~clk;

    typedef struct {
        bit          wb;
        logic [4:0]  dest;
        logic [31:0] data;
        bit          ill;
        string       req;
    } exp_t;

    exp_t exq[$];
    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [31:0] bcyc = '0;

    // model of the cycle counter requirement: zero in reset, +1 per edge after
    always @(posedge clk) bcyc <= rst_n ? bcyc + 32'd1 : 32'd0;

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(logic [4:0] num, logic [4:0] src, logic [4:0] dst);
        return {6'h2b, num, src, dst, 11'h5a5};
    endfunction

    task automatic do_read(logic [4:0] num, logic [4:0] dst, logic [31:0] exp, string req);
        exp_t e;
        csr_rd = 1'b1; insn = mk(num, 5'd0, dst);
        e.wb = 1; e.dest = dst; e.data = exp; e.ill = 0; e.req = req;
        exq.push_back(e);
        @(negedge clk);
        csr_rd = 1'b0;
    endtask

    task automatic do_write(logic [4:0] num, logic [4:0] src, logic [31:0] d, bit ill, string req);
        exp_t e;
        csr_wr = 1'b1; insn = mk(num, src, 5'd0); wr_data = d;
        e.wb = 0; e.dest = 5'd0; e.data = '0; e.ill = ill; e.req = req;
        exq.push_back(e);
        #1 chk("R11 source index", 128'(wr_src_idx), 128'(src));
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic pulse_ret(bit e, bit b);
        exc_ret = e; brk_ret = b;
        @(negedge clk);
        exc_ret = 1'b0; brk_ret = 1'b0;
    endtask

    // monitor: one response per issued instruction, compared one edge later
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exq.size() == 0) begin
                chk("R4 unexpected response", 128'(1), 128'(0));
            end else begin
                exp_t e;
                e = exq.pop_front();
                chk({e.req, " wb"}, 128'(rsp_wb), 128'(e.wb));
                chk({e.req, " illegal"}, 128'(rsp_illegal), 128'(e.ill));
                if (e.wb) begin
                    chk({e.req, " dest"}, 128'(rsp_dest), 128'(e.dest));
                    chk({e.req, " data"}, 128'(rsp_data), 128'(e.data));
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset int_en", 128'(int_en), 128'(0));
        chk("R5 reset exc_base", 128'(exc_base), 128'(0));
        chk("R9 reset bp_addr", 128'(bp_addr), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 no response when idle", 128'(rsp_valid), 128'(0));

        do_read(5'd0, 5'd3, 32'h0, "R1 IE after reset");
        do_read(5'd5, 5'd9, 32'h32, "R7 config word");

        // R1 / R4: write then read back-to-back
        do_write(5'd0, 5'd4, 32'hFFFF_FFF6, 0, "R1 write IE");
        do_read(5'd0, 5'd31, 32'h6, "R4 read after write IE");
        chk("R1 int_en low", 128'(int_en), 128'(0));

        pulse_ret(1, 0);
        chk("R2 eret sets IE from EIE", 128'(int_en), 128'(1));
        do_read(5'd0, 5'd1, 32'h7, "R2 IE after eret");

        do_write(5'd0, 5'd6, 32'h1, 0, "R3 write IE");
        pulse_ret(0, 1);
        chk("R3 bret clears IE from BIE", 128'(int_en), 128'(0));
        do_read(5'd0, 5'd2, 32'h0, "R3 IE after bret");

        do_write(5'd0, 5'd7, 32'h2, 0, "R2 write EIE only");
        pulse_ret(1, 1);
        chk("R2 eret wins over bret", 128'(int_en), 128'(1));
        do_read(5'd0, 5'd2, 32'h3, "R2 IE after both returns");

        // R5 base and debug registers
        do_write(5'd1, 5'd8, 32'h1234_5670, 0, "R5 write exc base");
        do_write(5'd2, 5'd9, 32'hCAFE_0100, 0, "R5 write dbg base");
        do_write(5'd3, 5'd10, 32'h0000_00A5, 0, "R5 write dbg ctl");
        chk("R5 exc_base port", 128'(exc_base), 128'(32'h1234_5670));
        chk("R5 dbg_base port", 128'(dbg_base), 128'(32'hCAFE_0100));
        chk("R5 dbg_ctl port", 128'(dbg_ctl), 128'(32'hA5));
        do_read(5'd1, 5'd11, 32'h1234_5670, "R5 read exc base");
        do_read(5'd2, 5'd12, 32'hCAFE_0100, "R5 read dbg base");
        do_read(5'd3, 5'd13, 32'hA5, "R5 read dbg ctl");

        // R6 cycle counter
        do_read(5'd4, 5'd14, bcyc, "R6 cycle count");
        repeat (5) @(negedge clk);
        do_read(5'd4, 5'd15, bcyc, "R6 cycle count later");
        do_write(5'd4, 5'd1, 32'h0, 0, "R6 write cycles ignored");
        do_read(5'd4, 5'd16, bcyc, "R6 cycle count after write");

        // R7 config write ignored
        do_write(5'd5, 5'd2, 32'hFFFF_FFFF, 0, "R7 write config ignored");
        do_read(5'd5, 5'd17, 32'h32, "R7 config after write");

        // R9 / R10 trigger registers
        do_write(5'd8, 5'd3, 32'hAAAA_0001, 0, "R9 write bp0");
        do_write(5'd9, 5'd4, 32'hBBBB_0002, 0, "R9 write bp1");
        do_write(5'd10, 5'd5, 32'hDEAD_0003, 1, "R10 write bp2 absent");
        do_write(5'd11, 5'd6, 32'hDEAD_0004, 1, "R10 write bp3 absent");
        chk("R9 bp_addr slots", 128'(bp_addr), {64'h0, 32'hBBBB_0002, 32'hAAAA_0001});
        do_write(5'd12, 5'd7, 32'h1111_0000, 0, "R9 write wp0");
        do_write(5'd13, 5'd8, 32'h2222_0000, 0, "R9 write wp1");
        do_write(5'd14, 5'd9, 32'h3333_0000, 0, "R9 write wp2");
        do_write(5'd15, 5'd10, 32'hDEAD_0005, 1, "R10 write wp3 absent");
        chk("R9 wp_addr slots", 128'(wp_addr),
            {32'h0, 32'h3333_0000, 32'h2222_0000, 32'h1111_0000});

        // R8 write-only and unassigned read zero
        do_write(5'd6, 5'd11, 32'h0F0F_0F0F, 0, "R8 write icache ctl");
        do_write(5'd20, 5'd12, 32'h1234, 0, "R8 write unassigned");
        do_read(5'd6, 5'd18, 32'h0, "R8 read icache ctl");
        do_read(5'd7, 5'd19, 32'h0, "R8 read dcache ctl");
        do_read(5'd8, 5'd20, 32'h0, "R8 read bp0");
        do_read(5'd12, 5'd21, 32'h0, "R8 read wp0");
        do_read(5'd11, 5'd22, 32'h0, "R10 read absent bp3 legal");
        do_read(5'd20, 5'd23, 32'h0, "R8 read unassigned");
        do_read(5'd1, 5'd24, 32'h1234_5670, "R8 exc base untouched");
        chk("R8 bp_addr untouched", 128'(bp_addr), {64'h0, 32'hBBBB_0002, 32'hAAAA_0001});

        repeat (2) @(negedge clk);
        chk("R4 all responses seen", 128'(exq.size()), 128'(0));
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule